// File: doc/BRIEF.md
# End-of-Interrupt Write Access Arbiter

This block sits beside the instruction decoder of a processor core and settles what happens when software issues a coprocessor-style write to the group-0 end-of-interrupt register. The caller presents the access encoding fields, the current exception level, the monitor-mode flag, whether levels 2 and 3 are present and which width they run at, and the relevant trap-control and register-interface-enable bits. One cycle later the block reports exactly one outcome. The possible outcomes are an undefined instruction, a trap to level 2 (in its 64-bit or 32-bit form, with syndrome code 3), a trap to level 3, a monitor trap, a redirect to the virtual register, or the physical register write.

The outcome is chosen by a cascade of checks that has a fixed priority and differs for each exception level. The block only decides the outcome. Taking the exception or performing the write is left to the logic that consumes the outcome. An access whose encoding does not match the register produces no outcome.

The decision is held in an enumerated state register. The states are ST_IDLE, ST_UNDEF, ST_TRAP2_A64, ST_TRAP2_A32, ST_TRAP3, ST_MONTRAP, ST_VIRTWR and ST_PHYSWR. On every clock edge the register moves to the verdict of the cascade when a matching request is present, and to ST_IDLE otherwise. Every state can therefore move to every other state in a single cycle. The outputs are decoded from the state alone.

Top module: `eoi_trap_arbiter`

## Requirements
- R1: A request matches only when cp=15, opc1=0, crn=12, crm=8 and opc2=1. When there is no request, or the request does not match, out_valid is low in the following cycle.
- R2: The outcome for a request sampled at a clock edge appears right after that edge with out_valid high. It lasts exactly one cycle unless another matching request follows.
- R3: out_outcome is one-hot while out_valid is high, and is all zero otherwise. The bits are: [0] undefined, [1] level-2 trap, [2] level-3 trap, [3] monitor trap, [4] virtual redirect, [5] physical write. out_syndrome is 3 for a level-2 or level-3 trap and 0 otherwise. out_l2_form64 is high only for a level-2 trap taken in 64-bit form.
- R4: At level 0 (req_level=0) the outcome is always undefined.
- R5: At level 1, when l2_enabled and trap_crn12 are both set, the outcome is a level-2 trap. This check takes priority over every other check. The form is 64-bit when l2_is32 is low. The trap bits of level 2 have no effect when l2_enabled is low.
- R6: At level 1, when R5 does not apply, a low sysif_en_l1 gives undefined.
- R7: At level 1, the next checks run in this order: l2_enabled with trap_all_g0 gives a level-2 trap, then l2_enabled with fiq_virt gives a virtual redirect.
- R8: At level 1, the next check is l3_present with fiq_to_l3. It gives a level-3 trap when l3_is32 is low. It gives a monitor trap when l3_is32 is high and req_monitor is low. When l3_is32 and req_monitor are both high, the check falls through. Any access that falls through is a physical write.
- R9: At level 2, a low sysif_en_l2 gives undefined. Otherwise l3_present with fiq_to_l3 gives a level-3 trap if level 3 is 64-bit, or a monitor trap if level 3 is 32-bit, whatever the value of req_monitor. Otherwise the access is a physical write.
- R10: At level 3, a low sysif_en_l3 gives undefined. Otherwise the access is a physical write.
- R11: During reset and in the cycle after it, out_valid is low and every outcome output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write access presented this cycle |
| req_level | input | 2 | Current exception level, 0 to 3 |
| req_monitor | input | 1 | Executing in monitor mode |
| l2_enabled | input | 1 | Level 2 is enabled for the current state |
| l2_is32 | input | 1 | Level 2 runs 32-bit |
| l3_present | input | 1 | Level 3 is implemented |
| l3_is32 | input | 1 | Level 3 runs 32-bit |
| trap_crn12 | input | 1 | Level-2 trap of accesses with crn=12 |
| trap_all_g0 | input | 1 | Level-2 trap of all group-0 interface accesses |
| fiq_virt | input | 1 | Level 2 routes fast interrupts, so accesses go to the virtual register |
| fiq_to_l3 | input | 1 | Fast interrupts are routed to level 3 |
| sysif_en_l1 | input | 1 | Register interface enabled at level 1 |
| sysif_en_l2 | input | 1 | Register interface enabled at level 2 |
| sysif_en_l3 | input | 1 | Register interface enabled at level 3 |
| enc_cp | input | 4 | Coprocessor number field |
| enc_opc1 | input | 3 | First opcode field |
| enc_crn | input | 4 | Primary register field |
| enc_crm | input | 4 | Secondary register field |
| enc_opc2 | input | 3 | Second opcode field |
| out_valid | output | 1 | Outcome present |
| out_outcome | output | 6 | One-hot outcome |
| out_l2_form64 | output | 1 | Level-2 trap taken in 64-bit form |
| out_syndrome | output | 6 | Syndrome code for a trap |

## Verification
Every result is due exactly one clock edge after its request is sampled. The bench changes inputs on the falling edge, lets one rising edge pass, and compares all outputs on the next falling edge. The expected values are computed before that edge from the inputs just driven. Idle and mismatched requests are checked in the same slot for a low out_valid, so a stale or stretched outcome from the previous vector shows up as a miscompare.

// File: rtl/eoi_trap_pkg.sv
package eoi_trap_pkg;

    localparam int OUTCOME_N = 6;
    localparam int OC_UNDEF  = 0;
    localparam int OC_TRAP2  = 1;
    localparam int OC_TRAP3  = 2;
    localparam int OC_MON    = 3;
    localparam int OC_VIRT   = 4;
    localparam int OC_PHYS   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNDEF,
        ST_TRAP2_A64,
        ST_TRAP2_A32,
        ST_TRAP3,
        ST_MONTRAP,
        ST_VIRTWR,
        ST_PHYSWR
    } arb_state_e;

    typedef struct packed {
        logic monitor;
        logic l2_enabled;
        logic l2_is32;
        logic l3_present;
        logic l3_is32;
    } exec_ctx_t;

    typedef struct packed {
        logic trap_crn12;
        logic trap_all_g0;
        logic fiq_virt;
        logic fiq_to_l3;
        logic sysif_en_l1;
        logic sysif_en_l2;
        logic sysif_en_l3;
    } trap_ctl_t;

endpackage

// File: rtl/eoi_enc_match.sv
module eoi_enc_match #(
    parameter int CP_W      = 4,
    parameter int OPC1_W    = 3,
    parameter int CRN_W     = 4,
    parameter int CRM_W     = 4,
    parameter int OPC2_W    = 3,
    parameter int CP_VAL    = 15,
    parameter int OPC1_VAL  = 0,
    parameter int CRN_VAL   = 12,
    parameter int CRM_VAL   = 8,
    parameter int OPC2_VAL  = 1
) (
    input  logic [CP_W-1:0]   cp,
    input  logic [OPC1_W-1:0] opc1,
    input  logic [CRN_W-1:0]  crn,
    input  logic [CRM_W-1:0]  crm,
    input  logic [OPC2_W-1:0] opc2,
    output logic              hit
);
    localparam logic [CP_W-1:0]   CP_K   = CP_W'(CP_VAL);
    localparam logic [OPC1_W-1:0] OPC1_K = OPC1_W'(OPC1_VAL);
    localparam logic [CRN_W-1:0]  CRN_K  = CRN_W'(CRN_VAL);
    localparam logic [CRM_W-1:0]  CRM_K  = CRM_W'(CRM_VAL);
    localparam logic [OPC2_W-1:0] OPC2_K = OPC2_W'(OPC2_VAL);

    logic [4:0] field_eq;

    always_comb begin
        field_eq[0] = (cp   == CP_K);
        field_eq[1] = (opc1 == OPC1_K);
        field_eq[2] = (crn  == CRN_K);
        field_eq[3] = (crm  == CRM_K);
        field_eq[4] = (opc2 == OPC2_K);
        hit         = &field_eq;
    end
endmodule

// File: rtl/eoi_level_cascade.sv
module eoi_level_cascade
    import eoi_trap_pkg::*;
#(
    parameter int LEVEL_W = 2
) (
    input  logic [LEVEL_W-1:0] level,
    input  exec_ctx_t          ctx,
    input  trap_ctl_t          ctl,
    output arb_state_e         verdict
);
    localparam logic [LEVEL_W-1:0] LVL1 = LEVEL_W'(1);
    localparam logic [LEVEL_W-1:0] LVL2 = LEVEL_W'(2);
    localparam logic [LEVEL_W-1:0] LVL3 = LEVEL_W'(3);

    arb_state_e l2_trap_kind;
    logic       fiq_l3_route;

    always_comb begin
        l2_trap_kind = ctx.l2_is32 ? ST_TRAP2_A32 : ST_TRAP2_A64;
        fiq_l3_route = ctx.l3_present && ctl.fiq_to_l3;
    end

    always_comb begin
        verdict = ST_UNDEF;
        unique case (level)
            LVL1: begin
                if (ctx.l2_enabled && ctl.trap_crn12)
                    verdict = l2_trap_kind;
                else if (!ctl.sysif_en_l1)
                    verdict = ST_UNDEF;
                else if (ctx.l2_enabled && ctl.trap_all_g0)
                    verdict = l2_trap_kind;
                else if (ctx.l2_enabled && ctl.fiq_virt)
                    verdict = ST_VIRTWR;
                else if (fiq_l3_route && !ctx.l3_is32)
                    verdict = ST_TRAP3;
                else if (fiq_l3_route && !ctx.monitor)
                    verdict = ST_MONTRAP;
                else
                    verdict = ST_PHYSWR;
            end
            LVL2: begin
                if (!ctl.sysif_en_l2)
                    verdict = ST_UNDEF;
                else if (fiq_l3_route)
                    verdict = ctx.l3_is32 ? ST_MONTRAP : ST_TRAP3;
                else
                    verdict = ST_PHYSWR;
            end
            LVL3: begin
                verdict = ctl.sysif_en_l3 ? ST_PHYSWR : ST_UNDEF;
            end
            default: begin
                verdict = ST_UNDEF;
            end
        endcase
    end
endmodule

// File: rtl/eoi_trap_arbiter.sv
module eoi_trap_arbiter
    import eoi_trap_pkg::*;
#(
    parameter int LEVEL_W   = 2,
    parameter int CP_W      = 4,
    parameter int OPC1_W    = 3,
    parameter int CRN_W     = 4,
    parameter int CRM_W     = 4,
    parameter int OPC2_W    = 3,
    parameter int SYND_W    = 6,
    parameter int SYND_CODE = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [LEVEL_W-1:0]   req_level,
    input  logic                 req_monitor,
    input  logic                 l2_enabled,
    input  logic                 l2_is32,
    input  logic                 l3_present,
    input  logic                 l3_is32,
    input  logic                 trap_crn12,
    input  logic                 trap_all_g0,
    input  logic                 fiq_virt,
    input  logic                 fiq_to_l3,
    input  logic                 sysif_en_l1,
    input  logic                 sysif_en_l2,
    input  logic                 sysif_en_l3,
    input  logic [CP_W-1:0]      enc_cp,
    input  logic [OPC1_W-1:0]    enc_opc1,
    input  logic [CRN_W-1:0]     enc_crn,
    input  logic [CRM_W-1:0]     enc_crm,
    input  logic [OPC2_W-1:0]    enc_opc2,
    output logic                 out_valid,
    output logic [OUTCOME_N-1:0] out_outcome,
    output logic                 out_l2_form64,
    output logic [SYND_W-1:0]    out_syndrome
);
    localparam logic [SYND_W-1:0] SYND_K = SYND_W'(SYND_CODE);

    logic       enc_hit;
    exec_ctx_t  ctx;
    trap_ctl_t  ctl;
    arb_state_e verdict;
    arb_state_e state_q;
    arb_state_e state_d;

    eoi_enc_match #(
        .CP_W(CP_W), .OPC1_W(OPC1_W), .CRN_W(CRN_W),
        .CRM_W(CRM_W), .OPC2_W(OPC2_W)
    ) u_match (
        .cp(enc_cp), .opc1(enc_opc1), .crn(enc_crn),
        .crm(enc_crm), .opc2(enc_opc2), .hit(enc_hit)
    );

    always_comb begin
        ctx = '{monitor: req_monitor, l2_enabled: l2_enabled, l2_is32: l2_is32,
                l3_present: l3_present, l3_is32: l3_is32};
        ctl = '{trap_crn12: trap_crn12, trap_all_g0: trap_all_g0,
                fiq_virt: fiq_virt, fiq_to_l3: fiq_to_l3,
                sysif_en_l1: sysif_en_l1, sysif_en_l2: sysif_en_l2,
                sysif_en_l3: sysif_en_l3};
    end

    eoi_level_cascade #(.LEVEL_W(LEVEL_W)) u_cascade (
        .level(req_level), .ctx(ctx), .ctl(ctl), .verdict(verdict)
    );

    always_comb begin
        state_d = (req_valid && enc_hit) ? verdict : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        out_valid     = 1'b1;
        out_outcome   = '0;
        out_l2_form64 = 1'b0;
        out_syndrome  = '0;
        unique case (state_q)
            ST_IDLE:      out_valid = 1'b0;
            ST_UNDEF:     out_outcome[OC_UNDEF] = 1'b1;
            ST_TRAP2_A64: begin
                out_outcome[OC_TRAP2] = 1'b1;
                out_l2_form64         = 1'b1;
                out_syndrome          = SYND_K;
            end
            ST_TRAP2_A32: begin
                out_outcome[OC_TRAP2] = 1'b1;
                out_syndrome          = SYND_K;
            end
            ST_TRAP3: begin
                out_outcome[OC_TRAP3] = 1'b1;
                out_syndrome          = SYND_K;
            end
            ST_MONTRAP:   out_outcome[OC_MON]  = 1'b1;
            ST_VIRTWR:    out_outcome[OC_VIRT] = 1'b1;
            ST_PHYSWR:    out_outcome[OC_PHYS] = 1'b1;
            default:      out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/eoi_trap_arbiter_chk.sv
module eoi_trap_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_level,
    input logic       req_monitor,
    input logic       l3_is32,
    input logic       sysif_en_l3,
    input logic [3:0] enc_cp,
    input logic [2:0] enc_opc1,
    input logic [3:0] enc_crn,
    input logic [3:0] enc_crm,
    input logic [2:0] enc_opc2,
    input logic       out_valid,
    input logic [5:0] out_outcome,
    input logic       out_l2_form64,
    input logic [5:0] out_syndrome
);
    logic chk_hit;
    assign chk_hit = req_valid && enc_cp == 4'd15 && enc_opc1 == 3'd0 &&
                     enc_crn == 4'd12 && enc_crm == 4'd8 && enc_opc2 == 3'd1;

    AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_hit |=> !out_valid); // R1
    AST_MATCH_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hit |=> out_valid); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_outcome) == 1); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_outcome == 6'd0 && !out_l2_form64 && out_syndrome == 6'd0)); // R3
    AST_TRAP_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
        (out_outcome[1] || out_outcome[2]) |-> out_syndrome == 6'd3); // R3
    AST_LEVEL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_hit && req_level == 2'd0) |=> out_outcome[0]); // R4
    AST_MONTRAP_NEEDS_32: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_hit && !l3_is32) |=> !out_outcome[3]); // R8
    AST_MON_MODE_NO_MONTRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_hit && req_level == 2'd1 && req_monitor) |=> !out_outcome[3]); // R8
    AST_LEVEL3_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_hit && req_level == 2'd3 && sysif_en_l3) |=> out_outcome[5]); // R10
endmodule

bind eoi_trap_arbiter eoi_trap_arbiter_chk u_chk (.*);

// File: tb/eoi_trap_arbiter_test.sv
`timescale 1ns/1ps
module eoi_trap_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_level = '0;
    logic       req_monitor = 1'b0, l2_enabled = 1'b0, l2_is32 = 1'b0;
    logic       l3_present = 1'b0, l3_is32 = 1'b0;
    logic       trap_crn12 = 1'b0, trap_all_g0 = 1'b0, fiq_virt = 1'b0, fiq_to_l3 = 1'b0;
    logic       sysif_en_l1 = 1'b1, sysif_en_l2 = 1'b1, sysif_en_l3 = 1'b1;
    logic [3:0] enc_cp = 4'd15;
    logic [2:0] enc_opc1 = 3'd0;
    logic [3:0] enc_crn = 4'd12;
    logic [3:0] enc_crm = 4'd8;
    logic [2:0] enc_opc2 = 3'd1;
    logic       out_valid, out_l2_form64;
    logic [5:0] out_outcome, out_syndrome;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    eoi_trap_arbiter uut (.*);

    function automatic void expect_of(output logic v, output logic [5:0] oc,
                                      output logic f64, output logic [5:0] syn,
                                      output string tag);
        logic hit;
        hit = req_valid && enc_cp == 4'd15 && enc_opc1 == 3'd0 && enc_crn == 4'd12 &&
              enc_crm == 4'd8 && enc_opc2 == 3'd1;
        v = hit; oc = '0; f64 = 1'b0; syn = '0; tag = "R1";
        if (!hit) return;
        case (req_level)
            2'd0: begin oc[0] = 1'b1; tag = "R4"; end
            2'd1: begin
                if (l2_enabled && trap_crn12) begin oc[1] = 1'b1; f64 = !l2_is32; tag = "R5"; end
                else if (!sysif_en_l1) begin oc[0] = 1'b1; tag = "R6"; end
                else if (l2_enabled && trap_all_g0) begin oc[1] = 1'b1; f64 = !l2_is32; tag = "R7"; end
                else if (l2_enabled && fiq_virt) begin oc[4] = 1'b1; tag = "R7"; end
                else if (l3_present && fiq_to_l3 && !l3_is32) begin oc[2] = 1'b1; tag = "R8"; end
                else if (l3_present && fiq_to_l3 && !req_monitor) begin oc[3] = 1'b1; tag = "R8"; end
                else begin oc[5] = 1'b1; tag = "R8"; end
            end
            2'd2: begin
                tag = "R9";
                if (!sysif_en_l2) oc[0] = 1'b1;
                else if (l3_present && fiq_to_l3) oc[l3_is32 ? 3 : 2] = 1'b1;
                else oc[5] = 1'b1;
            end
            default: begin tag = "R10"; oc[sysif_en_l3 ? 5 : 0] = 1'b1; end
        endcase
        if (oc[1] || oc[2]) syn = 6'd3;
    endfunction

    task automatic compare(input logic v, input logic [5:0] oc, input logic f64,
                           input logic [5:0] syn, input string tag);
        vectors++;
        if (out_valid !== v || out_outcome !== oc || out_l2_form64 !== f64 || out_syndrome !== syn) begin
            fails++;
            $display("FAIL %s (R2/R3 outputs): got v=%b oc=%b f64=%b syn=%0d exp v=%b oc=%b f64=%b syn=%0d",
                     tag, out_valid, out_outcome, out_l2_form64, out_syndrome, v, oc, f64, syn);
        end
    endtask

    // Inputs are set at a falling edge; the result is compared one rising edge later.
    task automatic apply();
        logic v, f64;
        logic [5:0] oc, syn;
        string tag;
        expect_of(v, oc, f64, syn, tag);
        @(posedge clk);
        @(negedge clk);
        compare(v, oc, f64, syn, tag);
    endtask

    task automatic set_ctx(input logic [1:0] lvl, input logic mon, input logic l2e, input logic l232,
                           input logic l3p, input logic l332);
        req_valid = 1'b1; req_level = lvl; req_monitor = mon; l2_enabled = l2e;
        l2_is32 = l232; l3_present = l3p; l3_is32 = l332;
        enc_cp = 4'd15; enc_opc1 = 3'd0; enc_crn = 4'd12; enc_crm = 4'd8; enc_opc2 = 3'd1;
    endtask

    task automatic set_ctl(input logic t12, input logic tall, input logic fv, input logic f3,
                           input logic s1, input logic s2, input logic s3);
        trap_crn12 = t12; trap_all_g0 = tall; fiq_virt = fv; fiq_to_l3 = f3;
        sysif_en_l1 = s1; sysif_en_l2 = s2; sysif_en_l3 = s3;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion, expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        compare(1'b0, 6'd0, 1'b0, 6'd0, "R11");   // R11 during reset
        rst_n = 1'b1;
        set_ctx(2'd0, 0, 0, 0, 0, 0); set_ctl(0, 0, 0, 0, 1, 1, 1);
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        compare(1'b0, 6'd0, 1'b0, 6'd0, "R11");   // R11 after reset

        // R1 each field off by one bit
        for (int f = 0; f < 5; f++) begin
            set_ctx(2'd3, 0, 0, 0, 0, 0);
            case (f)
                0: enc_cp[0] = 1'b0;
                1: enc_opc1[1] = 1'b1;
                2: enc_crn[2] = 1'b0;
                3: enc_crm[0] = 1'b1;
                default: enc_opc2[0] = 1'b0;
            endcase
            apply();
        end
        // R4 level 0 even with everything enabled
        set_ctx(2'd0, 0, 1, 0, 1, 0); set_ctl(0, 0, 1, 1, 1, 1, 1); apply();
        // R5 top priority, both forms; ignored when level 2 disabled
        set_ctx(2'd1, 0, 1, 0, 1, 0); set_ctl(1, 1, 1, 1, 0, 1, 1); apply();
        set_ctx(2'd1, 0, 1, 1, 1, 0); set_ctl(1, 0, 0, 0, 1, 1, 1); apply();
        set_ctx(2'd1, 0, 0, 0, 0, 0); set_ctl(1, 1, 1, 0, 1, 1, 1); apply();
        // R6 interface disabled beats trap-all
        set_ctx(2'd1, 0, 1, 0, 0, 0); set_ctl(0, 1, 1, 0, 0, 1, 1); apply();
        // R7 trap-all beats redirect; redirect beats level-3 routing
        set_ctx(2'd1, 0, 1, 1, 1, 0); set_ctl(0, 1, 1, 1, 1, 1, 1); apply();
        set_ctx(2'd1, 0, 1, 0, 1, 0); set_ctl(0, 0, 1, 1, 1, 1, 1); apply();
        // R8 three branches
        set_ctx(2'd1, 1, 0, 0, 1, 0); set_ctl(0, 0, 0, 1, 1, 1, 1); apply();
        set_ctx(2'd1, 0, 0, 0, 1, 1); set_ctl(0, 0, 0, 1, 1, 1, 1); apply();
        set_ctx(2'd1, 1, 0, 0, 1, 1); set_ctl(0, 0, 0, 1, 1, 1, 1); apply();
        // R9 level 2
        set_ctx(2'd2, 0, 1, 0, 1, 0); set_ctl(1, 1, 1, 1, 1, 0, 1); apply();
        set_ctx(2'd2, 1, 1, 0, 1, 1); set_ctl(1, 1, 1, 1, 1, 1, 1); apply();
        set_ctx(2'd2, 0, 1, 0, 1, 0); set_ctl(1, 1, 1, 1, 1, 1, 1); apply();
        set_ctx(2'd2, 0, 1, 0, 0, 0); set_ctl(1, 1, 1, 1, 1, 1, 1); apply();
        // R10 level 3
        set_ctx(2'd3, 0, 1, 0, 1, 1); set_ctl(1, 1, 1, 1, 1, 1, 0); apply();
        set_ctx(2'd3, 0, 1, 0, 1, 1); set_ctl(1, 1, 1, 1, 0, 0, 1); apply();
        // R2 outcome lasts one cycle once the request stops
        req_valid = 1'b0; apply();

        for (int n = 0; n < 3000; n++) begin
            set_ctx(2'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
            set_ctl(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0);
            req_valid = ($urandom % 10) != 0;
            if (($urandom % 5) == 0) begin
                enc_cp   = 4'($urandom);
                enc_opc1 = 3'($urandom);
                enc_crn  = 4'($urandom);
                enc_crm  = 4'($urandom);
                enc_opc2 = 3'($urandom);
            end
            apply();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule